// File: doc/BRIEF.md
# Staged Block Programming Controller

This block takes program-memory write requests from a processor register interface and gathers them in a staging buffer of four 14-bit words. Each request presents a word address, a data word, a write-enable and a one-cycle write strobe. A strobe counts only when a two-write unlock key has just been written to the key register, and only when the target address is not write-protected. The low two address bits pick the staging slot.

A strobe to slots 0 to 2 only fills the buffer. A strobe to slot 3 fills that slot and then commits all four words to the on-chip memory array. The commit starts at the block-aligned base, which is the request address with bits [1:0] forced to zero. The processor may finish one more instruction, so the block raises a one-cycle squash output telling the core to discard the instruction after that. It then holds a stall output for a programmable number of clock cycles, and ends with a one-cycle done pulse. Every commit leaves all four staging slots at 0x3FFF. A registered read port returns array contents.

Top module: `blkprog_ctrl`

## Requirements
- R1: The strobe loads `prog_data` into the slot selected by `prog_addr[1:0]`. When those bits are not 11, an accepted strobe raises `wr_flag` for exactly one cycle, starting on the edge that samples the strobe, and raises neither `squash` nor `stall`.
- R2: A strobe is accepted only if `wr_en` is high and the two key register writes just before it were 0x55 and then 0xAA, with no other key write between them. The reversed order, or no key at all, leaves the strobe without effect.
- R3: Any key write of another value resets the key detector. One strobe uses up the key, whether that strobe is accepted or not, so a second strobe without a new key has no effect.
- R4: An accepted strobe with `prog_addr[1:0]` = 11 writes staging slots 0 to 3 to array addresses base+0 to base+3, where base is `prog_addr` with bits [1:0] cleared.
- R5: After a committing strobe is sampled, `squash` is high for one cycle. Then `stall` is high for exactly PROG_CYCLES cycles, and `done` is high for the one cycle in which `stall` has just fallen. `wr_flag` stays high from the strobe until `stall` falls.
- R6: After each commit, all four staging slots hold 0x3FFF.
- R7: Write protection uses `wp_cfg` and address quarter q = `prog_addr[AW-1:AW-2]`. 11 protects nothing. 10 protects q=0. 01 protects q<2. 00 protects q<3. A refused strobe leaves `wr_flag` low, sets the sticky `wp_err`, and leaves the buffer unchanged.
- R8: A strobe while `squash` or `stall` is high is ignored. It starts no second commit and changes no array word.
- R9: After reset, `wr_flag`, `squash`, `stall`, `done` and `wp_err` are all low.
- R10: `rd_data` shows the array word at `rd_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Write to the unlock key register |
| key_data | input | 8 | Value written to the key register |
| prog_strobe | input | 1 | Write strobe, one cycle |
| wr_en | input | 1 | Write-enable qualifier for the strobe |
| prog_addr | input | AW | Target word address |
| prog_data | input | 14 | Data word for the selected slot |
| wp_cfg | input | 2 | Write-protect configuration |
| wr_flag | output | 1 | Write in progress flag |
| squash | output | 1 | Discard the next-but-one instruction |
| stall | output | 1 | Core stall during programming |
| done | output | 1 | One-cycle end-of-commit pulse |
| wp_err | output | 1 | Sticky protection error |
| rd_addr | input | AW | Array read address |
| rd_data | output | 14 | Array read data, registered |

## Verification
The hardest case to reach is a strobe arriving while a commit is still stalling. In a real system the core is halted then, so such a strobe can only come from a misbehaving requester. The bench forces it by issuing a complete unlock and a slot-3 strobe partway through the stall window of a commit. It aims that strobe at a block that was already programmed with known values. It then confirms that no second stall follows and that the earlier block still reads back unchanged. Refused writes are checked the same indirect way. A protected strobe lands between two accepted ones that fill one block, and the readback of that block shows that the staged word survived.

// File: rtl/blkprog_pkg.sv
package blkprog_pkg;

  localparam int unsigned WORD_W = 14;
  localparam int unsigned SLOTS  = 4;
  localparam logic [WORD_W-1:0] ERASED = 14'h3FFF;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SLIP,
    SQ_HOLD,
    SQ_DONE
  } seq_state_e;

  // Quarter-based protection: 11 none, 10 q0, 01 q0..q1, 00 q0..q2
  function automatic logic quarter_locked(input logic [1:0] cfg, input logic [1:0] q);
    logic r;
    case (cfg)
      2'b11:   r = 1'b0;
      2'b10:   r = (q == 2'd0);
      2'b01:   r = (q < 2'd2);
      default: r = (q < 2'd3);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/blkprog_unlock.sv
module blkprog_unlock #(
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_we,
  input  logic [7:0] key_data,
  input  logic       consume,
  output logic       armed
);

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_state_e;
  key_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= K_IDLE;
    end else if (consume) begin
      st <= K_IDLE;
    end else if (key_we) begin
      if (key_data == KEY_FIRST)
        st <= K_HALF;
      else if (st == K_HALF && key_data == KEY_SECOND)
        st <= K_ARMED;
      else
        st <= K_IDLE;
    end
  end

  assign armed = (st == K_ARMED);

  // R3
  key_consume_chk: assert property (@(posedge clk) disable iff (rst)
    consume |=> !armed);

  // R2
  key_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(key_we && key_data == KEY_SECOND));

endmodule

// File: rtl/blkprog_buffer.sv
module blkprog_buffer
  import blkprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        slot,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clear,
  output logic [WORD_W-1:0] words [SLOTS]
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear)
        words[i] <= ERASED;
      else if (load && slot == 2'(i))
        words[i] <= wdata;
    end
  end

  // R6
  buf_erase_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (words[0] == ERASED && words[1] == ERASED &&
               words[2] == ERASED && words[3] == ERASED));

endmodule

// File: rtl/blkprog_seq.sv
module blkprog_seq
  import blkprog_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [WORD_W-1:0] words [SLOTS],
  output logic              squash,
  output logic              stall,
  output logic              done,
  output logic              busy,
  output logic              last,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(PROG_CYCLES - 1);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic [AW-3:0] base_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      base_hi <= '0;
    end else begin
      case (st)
        SQ_IDLE, SQ_DONE: begin
          if (start) begin
            st      <= SQ_SLIP;
            base_hi <= start_addr[AW-1:2];
          end else begin
            st <= SQ_IDLE;
          end
        end
        SQ_SLIP: begin
          st  <= SQ_HOLD;
          cnt <= '0;
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) st <= SQ_DONE;
        end
      endcase
    end
  end

  assign squash    = (st == SQ_SLIP);
  assign stall     = (st == SQ_HOLD);
  assign done      = (st == SQ_DONE);
  assign busy      = squash | stall;
  assign last      = stall && (cnt == LAST_CNT);
  assign mem_we    = stall && (cnt < CW'(SLOTS));
  assign mem_addr  = {base_hi, cnt[1:0]};
  assign mem_wdata = words[cnt[1:0]];

  // R5
  slip_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
    squash |=> stall);

  // R5
  stall_len_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (cnt < CW'(PROG_CYCLES)));

  // R5
  done_after_stall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> done);

endmodule

// File: rtl/blkprog_array.sv
module blkprog_array
  import blkprog_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/blkprog_ctrl.sv
module blkprog_ctrl
  import blkprog_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [7:0]        key_data,
  input  logic              prog_strobe,
  input  logic              wr_en,
  input  logic [AW-1:0]     prog_addr,
  input  logic [WORD_W-1:0] prog_data,
  input  logic [1:0]        wp_cfg,
  output logic              wr_flag,
  output logic              squash,
  output logic              stall,
  output logic              done,
  output logic              wp_err,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic              armed, busy, last, locked;
  logic              accept, refuse, is_tail, hold_long;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [WORD_W-1:0] mem_wdata;
  logic [WORD_W-1:0] words [SLOTS];

  assign locked  = quarter_locked(wp_cfg, prog_addr[AW-1 -: 2]);
  assign is_tail = (prog_addr[1:0] == 2'b11);
  assign accept  = prog_strobe && wr_en && armed && !busy && !locked;
  assign refuse  = prog_strobe && wr_en && armed && !busy && locked;

  blkprog_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .key_we   (key_we),
    .key_data (key_data),
    .consume  (prog_strobe),
    .armed    (armed)
  );

  blkprog_buffer u_buffer (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .slot  (prog_addr[1:0]),
    .wdata (prog_data),
    .clear (last),
    .words (words)
  );

  blkprog_seq #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept && is_tail),
    .start_addr (prog_addr),
    .words      (words),
    .squash     (squash),
    .stall      (stall),
    .done       (done),
    .busy       (busy),
    .last       (last),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  blkprog_array #(.AW(AW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_flag   <= 1'b0;
      hold_long <= 1'b0;
    end else if (accept) begin
      wr_flag   <= 1'b1;
      hold_long <= is_tail;
    end else if (!hold_long || last) begin
      wr_flag   <= 1'b0;
      hold_long <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         wp_err <= 1'b0;
    else if (refuse) wp_err <= 1'b1;
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wp_err |=> wp_err);

  // R1
  short_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && !squash && !stall) |=> !wr_flag);

  // R8
  single_commit_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !squash);

  // R5
  flag_cover_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> wr_flag);

endmodule

// File: tb/blkprog_ctrl_test.sv
module blkprog_ctrl_test;

  localparam int unsigned AW   = 8;
  localparam int unsigned PROG = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_we = 1'b0;
  logic [7:0]  key_data = '0;
  logic        prog_strobe = 1'b0;
  logic        wr_en = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [13:0] prog_data = '0;
  logic [1:0]  wp_cfg = 2'b11;
  logic        wr_flag, squash, stall, done, wp_err;
  logic [AW-1:0] rd_addr = '0;
  logic [13:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  blkprog_ctrl #(.AW(AW), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst(rst), .key_we(key_we), .key_data(key_data),
    .prog_strobe(prog_strobe), .wr_en(wr_en), .prog_addr(prog_addr),
    .prog_data(prog_data), .wp_cfg(wp_cfg), .wr_flag(wr_flag),
    .squash(squash), .stall(stall), .done(done), .wp_err(wp_err),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic key_write(input logic [7:0] v);
    @(negedge clk); key_we = 1'b1; key_data = v;
    @(negedge clk); key_we = 1'b0;
  endtask

  // strobe; returns at the negedge after the sampling edge
  task automatic strobe(input logic [AW-1:0] a, input logic [13:0] d);
    @(negedge clk);
    prog_strobe = 1'b1; wr_en = 1'b1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_strobe = 1'b0; wr_en = 1'b0;
  endtask

  task automatic keyed_write(input logic [AW-1:0] a, input logic [13:0] d);
    @(negedge clk); key_we = 1'b1; key_data = 8'h55;
    @(negedge clk); key_data = 8'hAA;
    @(negedge clk); key_we = 1'b0;
    prog_strobe = 1'b1; wr_en = 1'b1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_strobe = 1'b0; wr_en = 1'b0;
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [13:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((stall || squash) && guard < 1000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!wr_flag && !squash && !stall && !done && !wp_err, "R9", "reset outputs",
          {wr_flag, squash, stall, done, wp_err}, 0);
  endtask

  task automatic t_short();
    keyed_write(8'hFC, 14'h0111);
    check(wr_flag == 1'b1, "R1", "flag after short strobe", wr_flag, 1);
    check(!squash && !stall, "R1", "no stall on short", {squash, stall}, 0);
    @(negedge clk);
    check(wr_flag == 1'b0, "R1", "flag one cycle", wr_flag, 0);
  endtask

  task automatic t_commit_top();
    int n = 0;
    logic [13:0] v;
    keyed_write(8'hFD, 14'h0222);
    keyed_write(8'hFE, 14'h0333);
    keyed_write(8'hFF, 14'h0444);
    check(squash == 1'b1 && stall == 1'b0, "R5", "squash cycle", {squash, stall}, 2);
    check(wr_flag == 1'b1, "R5", "flag at commit", wr_flag, 1);
    @(negedge clk);
    while (stall && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == PROG, "R5", "stall length", n, PROG);
    check(done == 1'b1 && wr_flag == 1'b0, "R5", "done as stall falls", {done, wr_flag}, 2);
    @(negedge clk);
    check(done == 1'b0, "R5", "done one cycle", done, 0);
    for (int i = 0; i < 4; i++) begin
      read_word(8'hFC + 8'(i), v);
      check(v == 14'h0111 * 14'(i + 1), "R4", "committed word", v, 14'h0111 * (i + 1));
    end
    read_word(8'hFF, v);
    check(v == 14'h0444, "R10", "read port word", v, 14'h0444);
  endtask

  task automatic t_erase_and_busy();
    logic [13:0] v;
    keyed_write(8'h47, 14'h0555);
    // R8: keyed strobe to the already programmed top block during stall
    keyed_write(8'hFF, 14'h1234);
    wait_idle();
    repeat (20) begin
      @(negedge clk);
      check(!stall && !squash, "R8", "no second commit", {squash, stall}, 0);
    end
    read_word(8'hFF, v);
    check(v == 14'h0444, "R8", "array untouched by busy strobe", v, 14'h0444);
    for (int i = 0; i < 3; i++) begin
      read_word(8'h44 + 8'(i), v);
      check(v == 14'h3FFF, "R6", "erased slot committed", v, 14'h3FFF);
    end
    read_word(8'h47, v);
    check(v == 14'h0555, "R4", "tail word", v, 14'h0555);
  endtask

  task automatic t_keys();
    strobe(8'h20, 14'h0001);
    check(wr_flag == 1'b0, "R2", "no key", wr_flag, 0);
    key_write(8'h55); key_write(8'h12); key_write(8'hAA);
    strobe(8'h20, 14'h0002);
    check(wr_flag == 1'b0, "R3", "broken key", wr_flag, 0);
    key_write(8'hAA); key_write(8'h55);
    strobe(8'h20, 14'h0003);
    check(wr_flag == 1'b0, "R2", "reversed key", wr_flag, 0);
    keyed_write(8'h20, 14'h0004);
    check(wr_flag == 1'b1, "R2", "good key", wr_flag, 1);
    @(negedge clk);
    strobe(8'h21, 14'h0005);
    check(wr_flag == 1'b0, "R3", "key consumed", wr_flag, 0);
  endtask

  task automatic t_protect();
    logic [13:0] v;
    wp_cfg = 2'b11;
    keyed_write(8'h80, 14'h0ABC);
    check(wr_flag == 1'b1 && wp_err == 1'b0, "R7", "open write", {wr_flag, wp_err}, 2);
    wp_cfg = 2'b10;
    keyed_write(8'h04, 14'h0111);
    check(wr_flag == 1'b0 && wp_err == 1'b1, "R7", "q0 locked by 10", {wr_flag, wp_err}, 1);
    wp_cfg = 2'b01;
    keyed_write(8'h7C, 14'h0222);
    check(wr_flag == 1'b0, "R7", "q1 locked by 01", wr_flag, 0);
    wp_cfg = 2'b00;
    keyed_write(8'hBC, 14'h0333);
    check(wr_flag == 1'b0, "R7", "q2 locked by 00", wr_flag, 0);
    wp_cfg = 2'b10;
    keyed_write(8'h41, 14'h0999);
    check(wr_flag == 1'b1 && wp_err == 1'b1, "R7", "q1 open under 10, err sticky",
          {wr_flag, wp_err}, 3);
    wp_cfg = 2'b11;
    keyed_write(8'h82, 14'h0CCC);
    keyed_write(8'h83, 14'h0DDD);
    wait_idle();
    read_word(8'h80, v);
    check(v == 14'h0ABC, "R7", "buffer kept after refusal", v, 14'h0ABC);
    read_word(8'h81, v);
    check(v == 14'h0999, "R1", "slot from low bits", v, 14'h0999);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_short();
    t_commit_top();
    t_erase_and_busy();
    t_keys();
    t_protect();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule